// File: doc/BRIEF.md
# Scan-Register Bus Bridge

This block sits between a 64-bit memory-mapped request port and an internal bus of scan registers. Each accepted request carries a byte address. The bridge masks that address to the bridge window and turns it into a register index. The bit rule used for that step is picked per request by a generation-select input. A short list of housekeeping indices is answered inside the bridge: an identity register and a set of registers that read as zero and drop writes. Every other access goes downstream at byte address `index << 3` over a valid/ready request channel, and the bridge then waits for a response strobe.

Only one transaction is in flight at a time. The upstream port stays not-ready from acceptance until the response pulse. Every finished transaction pulses `rsp_valid` and sets a sticky done flag. A failure sets a sticky fail flag as well. A failure is a downstream error, a non-8-byte access, or no downstream progress within the timeout window. Software clears the flags through a write-1-to-clear input. Data words pass through as whole 64-bit big-endian words, with no byte reordering.

Top module: `regbus_bridge`

## Requirements
- R1: Address bits at or above the window width (`WIN_W`, default 35) are ignored. Only `req_addr[WIN_W-1:0]` takes part in translation.
- R2: With `gen_new`=1 the index is the masked address shifted right by 3. A forwarded request is presented on `dn_addr` as index·8, so `dn_addr[2:0]` is always zero.
- R3: With `gen_new`=0 the index takes masked-address bits [6:3] as its bits [3:0], and masked-address bits [WIN_W-1:8] as its bits [WIN_W-5:4]. Address bit 7 has no effect.
- R4: A read of index 0xF000F returns the `CHIP_ID` parameter without any downstream access. A write to that index completes without error and is not forwarded.
- R5: Reads of these indices return zero locally and are not forwarded: 0x18002, 0x1010C00, 0x1010C03, 0x90012, 0x90013, 0x90018, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x2020007, 0x2020009, 0x202000F, 0x2013028, 0x201302A, 0x2013801, 0x2013802.
- R6: Writes to these indices are dropped locally without error: 0x1010C00 through 0x1010C05, and every index in R5 except 0x18002. A read of 0x1010C01 and a write to 0x18002 are forwarded.
- R7: Reads of indices 0x2013F00 through 0x2013F07 return zero locally. Writes to them are forwarded downstream.
- R8: Every finished transaction raises `rsp_valid` for exactly one cycle, with `stat_done` set from that cycle on. Write responses carry zero data.
- R9: A downstream response with `dn_rsp_err`=1 gives `rsp_err`=1, zero `rsp_rdata`, and sets `stat_fail`. A clean forwarded read returns `dn_rsp_rdata`.
- R10: `stat_clr[0]` clears `stat_done` and `stat_clr[1]` clears `stat_fail`, each after one clock edge. A completion in the same cycle wins over the clear.
- R11: A request whose `req_size` is not 8 finishes with `rsp_err`=1 and sets `stat_fail`, without a downstream access.
- R12: `req_ready` is low from acceptance until the response pulse. While `dn_valid` is high and `dn_ready` is low, `dn_valid` and `dn_addr` hold.
- R13: If the downstream side does not respond within `TMO_CYC` (default 256) cycles of the request being issued, the transaction finishes as a failure and `dn_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_new | input | 1 | Translation rule select, sampled with the request (1 = shift-by-3 rule) |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (40) | Byte address |
| req_size | input | 4 | Access size in bytes; only 8 is valid |
| req_wdata | input | DATA_W (64) | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion failed |
| rsp_rdata | output | DATA_W (64) | Read data (zero on failure or write) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | WIN_W (35) | Downstream byte address, index·8 |
| dn_wdata | output | DATA_W (64) | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_err | input | 1 | Downstream response error |
| dn_rsp_rdata | input | DATA_W (64) | Downstream read data |
| stat_clr | input | 2 | Write-1-to-clear: bit 0 done, bit 1 fail |
| stat_done | output | 1 | Sticky done flag |
| stat_fail | output | 1 | Sticky fail flag |

## Verification
The table of vectors runs both translation rules against addresses that land on the identity index, on the read-zero list, on the write-ignore list, and on ordinary forwarded indices. Addresses with bit 7 set and with bits above the window set show whether those bits are really discarded. Pairs of read and write to the same index (0x18002, 0x1010C01, 0x2013F0x) separate the read table from the write table, and the downstream address each forward lands on separates the legacy swizzle from the plain shift. Directed runs then drive an erroring downstream, a wrong access size and a silent downstream, to tell the three failure sources apart from the write-1-to-clear behaviour of each flag.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_DN_REQ,
    ST_DN_WAIT,
    ST_RESP
  } rb_state_e;

  localparam logic [31:0] IDX_CHIP_ID = 32'h000F_000F;

  // Indices answered locally on a read (identity index included).
  function automatic logic rd_is_local(input logic [31:0] i);
    logic hit;
    case (i) inside
      IDX_CHIP_ID,
      32'h0001_8002,
      32'h0101_0C00, 32'h0101_0C03,
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h0102_0013, 32'h0102_0014,
      32'h000F_0033, 32'h000F_0034,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
      32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802,
      [32'h0201_3F00:32'h0201_3F07]: hit = 1'b1;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Indices whose writes are dropped locally.
  function automatic logic wr_is_local(input logic [31:0] i);
    logic hit;
    case (i) inside
      IDX_CHIP_ID,
      [32'h0101_0C00:32'h0101_0C05],
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h0102_0013, 32'h0102_0014,
      32'h000F_0033, 32'h000F_0034,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
      32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802: hit = 1'b1;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/rb_xlate.sv
module rb_xlate #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned WIN_W  = 35,
  localparam int unsigned IDX_W = WIN_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              gen_new,
  output logic [IDX_W-1:0]  idx,
  output logic [WIN_W-1:0]  fwd_addr
);

  localparam logic [WIN_W-1:0] NIB = WIN_W'(15);

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] idx_new;
  logic [WIN_W-1:0] idx_leg;

  generate
    if (ADDR_W > WIN_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:WIN_W];
    end
  endgenerate

  assign win     = addr[WIN_W-1:0];
  assign idx_new = win >> 3;
  assign idx_leg = ((win >> 4) & ~NIB) | ((win >> 3) & NIB);

  logic unused_lo;
  assign unused_lo = ^{win[2:0], idx_new[WIN_W-1:IDX_W], idx_leg[WIN_W-1:IDX_W]};

  assign idx      = gen_new ? idx_new[IDX_W-1:0] : idx_leg[IDX_W-1:0];
  assign fwd_addr = {idx, 3'b000};

endmodule

// File: rtl/rb_local_map.sv
module rb_local_map
  import rb_pkg::*;
#(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned DATA_W = 64,
  parameter logic [DATA_W-1:0] CHIP_ID = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [DATA_W-1:0] rd_val
);

  logic [31:0] idx32;
  logic        hi_zero;

  generate
    if (IDX_W > 32) begin : g_wide
      assign idx32   = idx[31:0];
      assign hi_zero = ~|idx[IDX_W-1:32];
    end else begin : g_narrow
      assign idx32   = 32'(idx);
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign rd_hit = hi_zero & rd_is_local(idx32);
  assign wr_hit = hi_zero & wr_is_local(idx32);
  assign rd_val = (hi_zero && idx32 == IDX_CHIP_ID) ? CHIP_ID : '0;

endmodule

// File: rtl/rb_timer.sv
module rb_timer #(
  parameter int unsigned LIMIT = 256,
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/regbus_bridge.sv
module regbus_bridge
  import rb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned WIN_W   = 35,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned TMO_CYC = 256,
  parameter logic [DATA_W-1:0] CHIP_ID = 64'h0000_00D1_C0DE_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_new,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [WIN_W-1:0]  dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic              dn_rsp_err,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic [1:0]        stat_clr,
  output logic              stat_done,
  output logic              stat_fail
);

  localparam int unsigned IDX_W = WIN_W - 3;
  localparam logic [3:0]  WORD_BYTES = 4'd8;

  rb_state_e state_q, state_d;

  logic              q_write, q_gen, q_size_ok;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;

  logic [IDX_W-1:0]  idx;
  logic [WIN_W-1:0]  fwd_addr;
  logic              rd_hit, wr_hit;
  logic [DATA_W-1:0] loc_val;
  logic              tmo;

  logic              fin, fin_err, launch, dn_drop;
  logic [DATA_W-1:0] fin_data;

  logic              dn_valid_q, dn_write_q;
  logic [WIN_W-1:0]  dn_addr_q;
  logic [DATA_W-1:0] dn_wdata_q;
  logic              rsp_valid_q, rsp_err_q, done_q, fail_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  rb_xlate #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) xlate_i (
    .addr     (q_addr),
    .gen_new  (q_gen),
    .idx      (idx),
    .fwd_addr (fwd_addr)
  );

  rb_local_map #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID)) map_i (
    .idx    (idx),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit),
    .rd_val (loc_val)
  );

  rb_timer #(.LIMIT(TMO_CYC)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_DN_REQ || state_q == ST_DN_WAIT),
    .expired (tmo)
  );

  // Next-state and completion decode.
  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_err  = 1'b0;
    fin_data = '0;
    launch   = 1'b0;
    dn_drop  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (!q_size_ok) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else if (q_write ? wr_hit : rd_hit) begin
          fin      = 1'b1;
          fin_data = q_write ? '0 : loc_val;
        end else begin
          launch  = 1'b1;
          state_d = ST_DN_REQ;
        end
      end
      ST_DN_REQ: begin
        if (dn_ready) begin
          dn_drop = 1'b1;
          state_d = ST_DN_WAIT;
        end else if (tmo) begin
          dn_drop = 1'b1;
          fin     = 1'b1;
          fin_err = 1'b1;
        end
      end
      ST_DN_WAIT: begin
        if (dn_rsp_valid) begin
          fin      = 1'b1;
          fin_err  = dn_rsp_err;
          fin_data = (dn_rsp_err || q_write) ? '0 : dn_rsp_rdata;
        end else if (tmo) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_RESP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Request capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_write   <= 1'b0;
      q_gen     <= 1'b0;
      q_size_ok <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
    end else if (state_q == ST_IDLE && req_valid) begin
      q_write   <= req_write;
      q_gen     <= gen_new;
      q_size_ok <= (req_size == WORD_BYTES);
      q_addr    <= req_addr;
      q_wdata   <= req_wdata;
    end
  end

  // Downstream request channel.
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid_q <= 1'b0;
      dn_write_q <= 1'b0;
      dn_addr_q  <= '0;
      dn_wdata_q <= '0;
    end else if (launch) begin
      dn_valid_q <= 1'b1;
      dn_write_q <= q_write;
      dn_addr_q  <= fwd_addr;
      dn_wdata_q <= q_write ? q_wdata : '0;
    end else if (dn_drop) begin
      dn_valid_q <= 1'b0;
    end
  end

  // Response and sticky status.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      rsp_valid_q <= fin;
      if (fin) begin
        rsp_err_q   <= fin_err;
        rsp_rdata_q <= fin_data;
      end
      done_q <= fin | (done_q & ~stat_clr[0]);
      fail_q <= (fin & fin_err) | (fail_q & ~stat_clr[1]);
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign dn_valid  = dn_valid_q;
  assign dn_write  = dn_write_q;
  assign dn_addr   = dn_addr_q;
  assign dn_wdata  = dn_wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign stat_done = done_q;
  assign stat_fail = fail_q;

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int unsigned WIN_W  = 35,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [WIN_W-1:0]  dn_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [1:0]        stat_clr,
  input logic              stat_done,
  input logic              stat_fail
);

  assert_busy_while_fwd_R12: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> !req_ready);

  assert_accept_blocks_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_dn_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> $stable(dn_addr));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_addr[2:0] == 3'b000));

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_done_on_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> stat_done);

  assert_fail_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (stat_fail && rsp_rdata == '0));

  assert_clr_done_R10: assert property (@(posedge clk) disable iff (rst)
    stat_clr[0] |=> (!stat_done || rsp_valid));

  assert_clr_fail_R10: assert property (@(posedge clk) disable iff (rst)
    stat_clr[1] |=> (!stat_fail || (rsp_valid && rsp_err)));

endmodule

bind regbus_bridge rb_checker #(.WIN_W(WIN_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dn_valid  (dn_valid),
  .dn_ready  (dn_ready),
  .dn_addr   (dn_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .stat_clr  (stat_clr),
  .stat_done (stat_done),
  .stat_fail (stat_fail)
);

// File: tb/regbus_bridge_tb_top.sv
module regbus_bridge_tb_top;

  localparam int CLK_P = 10;
  localparam logic [63:0] ID_VAL = 64'h5A00_0000_ABCD_0042;
  localparam logic [63:0] DN_SALT = 64'hC3C3_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_new = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        dn_valid, dn_write;
  logic        dn_ready = 1'b0, dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
  logic [34:0] dn_addr;
  logic [63:0] dn_wdata, dn_rsp_rdata = '0;
  logic [1:0]  stat_clr = 2'b00;
  logic        stat_done, stat_fail;

  always #(CLK_P/2) clk = ~clk;

  regbus_bridge #(.CHIP_ID(ID_VAL)) dut_i (
    .clk(clk), .rst(rst), .gen_new(gen_new),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata),
    .stat_clr(stat_clr), .stat_done(stat_done), .stat_fail(stat_fail)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Downstream model: 0 = normal, 1 = error response, 2 = silent.
  int          dn_mode = 0;
  bit          seen = 0, seen_wr = 0;
  logic [34:0] seen_addr = '0;
  logic [63:0] seen_data = '0;

  initial begin
    forever begin
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      dn_rsp_err   = 1'b0;
      dn_rsp_rdata = '0;
      if (dn_valid && !dn_ready) begin
        seen = 1; seen_wr = dn_write; seen_addr = dn_addr; seen_data = dn_wdata;
        if (dn_mode != 2) begin
          dn_ready = 1'b1;
          @(negedge clk);
          dn_ready = 1'b0;
          repeat (2) @(negedge clk);
          dn_rsp_valid = 1'b1;
          dn_rsp_err   = (dn_mode == 1);
          dn_rsp_rdata = {29'h0, seen_addr} ^ DN_SALT;
        end
      end
    end
  end

  logic [63:0] got_data;
  logic        got_err;
  int          got_cyc;
  bit          busy_low;

  task automatic access(input bit wr, input bit gen, input logic [39:0] a,
                        input logic [63:0] wd, input logic [3:0] sz);
    @(negedge clk);
    seen = 0;
    gen_new = gen; req_write = wr; req_addr = a; req_wdata = wd; req_size = sz;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_cyc = 1;
    busy_low = 1;
    while (!rsp_valid && got_cyc < 2000) begin
      if (req_ready) busy_low = 0;
      @(negedge clk);
      got_cyc++;
    end
    got_data = rsp_rdata;
    got_err  = rsp_err;
    chk(rsp_valid, "R8", "response pulse seen", 64'(rsp_valid), 64'd1);
    chk(stat_done, "R8", "done set at response", 64'(stat_done), 64'd1);
    @(negedge clk);
    chk(!rsp_valid, "R8", "response lasts one cycle", 64'(rsp_valid), 64'd0);
  endtask

  typedef struct packed {
    logic        wr;
    logic        gen;
    logic [39:0] addr;
    logic        fwd;
    logic [34:0] fwd_addr;
    logic [63:0] rd_exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 40'h00_0078_0078, 1'b0, 35'h0, ID_VAL},          // R2 R4 identity
    '{1'b0, 1'b0, 40'h00_00F0_0078, 1'b0, 35'h0, ID_VAL},          // R3 R4
    '{1'b0, 1'b0, 40'h00_00F0_00F8, 1'b0, 35'h0, ID_VAL},          // R3 bit 7 ignored
    '{1'b1, 1'b1, 40'h00_0078_0078, 1'b0, 35'h0, 64'h0},           // R4 write dropped
    '{1'b0, 1'b1, 40'h00_000C_0010, 1'b0, 35'h0, 64'h0},           // R5 0x18002
    '{1'b1, 1'b1, 40'h00_000C_0010, 1'b1, 35'h0_000C_0010, 64'h0}, // R6 0x18002 write goes out
    '{1'b0, 1'b1, 40'h00_0808_6008, 1'b1, 35'h0_0808_6008, 64'h0}, // R6 0x1010C01 read goes out
    '{1'b1, 1'b1, 40'h00_0808_6008, 1'b0, 35'h0, 64'h0},           // R6 0x1010C01 write dropped
    '{1'b0, 1'b1, 40'h00_1009_F838, 1'b0, 35'h0, 64'h0},           // R7 0x2013F07 read zero
    '{1'b1, 1'b1, 40'h00_1009_F838, 1'b1, 35'h0_1009_F838, 64'h0}, // R7 write forwarded
    '{1'b0, 1'b0, 40'h00_2013_F018, 1'b0, 35'h0, 64'h0},           // R7 R3 0x2013F03
    '{1'b1, 1'b0, 40'h00_2013_F018, 1'b1, 35'h0_1009_F818, 64'h0}, // R7 R3 write forwarded
    '{1'b0, 1'b1, 40'h80_0048_0090, 1'b0, 35'h0, 64'h0},           // R1 0x90012 with high bit
    '{1'b0, 1'b1, 40'h80_0000_1238, 1'b1, 35'h0_0000_1238, 64'h0}, // R1 R2 forward
    '{1'b0, 1'b0, 40'h00_0000_1234, 1'b1, 35'h0_0000_0930, 64'h0}, // R3 forward
    '{1'b1, 1'b1, 40'h00_0078_01A0, 1'b0, 35'h0, 64'h0},           // R6 0xF0034
    '{1'b0, 1'b1, 40'h00_0810_0098, 1'b0, 35'h0, 64'h0},           // R5 0x1020013
    '{1'b1, 1'b0, 40'h00_2020_0048, 1'b0, 35'h0, 64'h0}            // R6 R3 0x2020009
  };

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready after reset", 64'(req_ready), 64'd1);
    chk(!dn_valid && !rsp_valid, "R8", "quiet after reset", {dn_valid, rsp_valid}, 64'd0);
    chk(!stat_done && !stat_fail, "R10", "flags clear after reset", {stat_done, stat_fail}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      logic [63:0] wd;
      logic [63:0] exp_rd;
      wd = 64'hFEED_0000_0000_0000 | 64'(k);
      access(TBL[k].wr, TBL[k].gen, TBL[k].addr, wd, 4'd8);
      chk(seen == TBL[k].fwd, "R2", $sformatf("vec %0d forwarded", k), 64'(seen), 64'(TBL[k].fwd));
      chk(!got_err, "R9", $sformatf("vec %0d no error", k), 64'(got_err), 64'd0);
      if (TBL[k].fwd) begin
        chk(seen_addr == TBL[k].fwd_addr, "R3", $sformatf("vec %0d dn_addr", k),
            64'(seen_addr), 64'(TBL[k].fwd_addr));
        chk(seen_wr == TBL[k].wr, "R6", $sformatf("vec %0d dn_write", k), 64'(seen_wr), 64'(TBL[k].wr));
        if (TBL[k].wr)
          chk(seen_data == wd, "R7", $sformatf("vec %0d dn_wdata", k), seen_data, wd);
      end
      if (TBL[k].wr) exp_rd = '0;
      else if (TBL[k].fwd) exp_rd = {29'h0, TBL[k].fwd_addr} ^ DN_SALT;
      else exp_rd = TBL[k].rd_exp;
      chk(got_data == exp_rd, "R5", $sformatf("vec %0d read data", k), got_data, exp_rd);
    end
    chk(!stat_fail, "R9", "no fail after clean table", 64'(stat_fail), 64'd0);

    // R9: downstream error
    dn_mode = 1;
    access(1'b0, 1'b1, 40'h00_0000_1238, '0, 4'd8);
    chk(got_err, "R9", "error propagated", 64'(got_err), 64'd1);
    chk(got_data == '0, "R9", "failed read data zero", got_data, 64'd0);
    chk(stat_fail, "R9", "fail flag set", 64'(stat_fail), 64'd1);
    dn_mode = 0;

    // R10: clear fail only, then done only
    @(negedge clk); stat_clr = 2'b10;
    @(negedge clk); stat_clr = 2'b00;
    chk(!stat_fail, "R10", "fail cleared", 64'(stat_fail), 64'd0);
    chk(stat_done, "R10", "done kept by fail clear", 64'(stat_done), 64'd1);
    stat_clr = 2'b01;
    @(negedge clk); stat_clr = 2'b00;
    chk(!stat_done, "R10", "done cleared", 64'(stat_done), 64'd0);

    // R11: wrong access size to a forwarded index
    access(1'b0, 1'b1, 40'h00_0000_1238, '0, 4'd4);
    chk(got_err, "R11", "bad size fails", 64'(got_err), 64'd1);
    chk(!seen, "R11", "bad size not forwarded", 64'(seen), 64'd0);
    chk(stat_fail, "R11", "bad size sets fail", 64'(stat_fail), 64'd1);
    @(negedge clk); stat_clr = 2'b11;
    @(negedge clk); stat_clr = 2'b00;

    // R13: silent downstream
    dn_mode = 2;
    access(1'b1, 1'b1, 40'h00_0000_2000, 64'h1, 4'd8);
    chk(got_err, "R13", "timeout fails", 64'(got_err), 64'd1);
    chk(got_cyc >= 256 && got_cyc <= 262, "R13", "timeout latency", 64'(got_cyc), 64'd257);
    chk(busy_low, "R12", "ready low while outstanding", 64'(busy_low), 64'd1);
    chk(!dn_valid, "R13", "request dropped after timeout", 64'(dn_valid), 64'd0);
    chk(stat_fail, "R13", "timeout sets fail", 64'(stat_fail), 64'd1);
    chk(req_ready, "R12", "ready again after response", 64'(req_ready), 64'd1);
    dn_mode = 0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule